// File: doc/BRIEF.md
# MAC Interrupt Status and Control Register Bank

This block is the 32-bit register bank that sits in front of an Ethernet MAC DMA controller. It holds the command word that switches the transmit and receive paths on, the interrupt-enable mask and the sticky interrupt-status word. It also holds six plain configuration words: the two descriptor-list start addresses, the FIFO threshold, the maximum receive frame size, the missed-frame counter and the management data/address word. The TX and RX DMA engines pulse event bits into the status word. Each event bit is latched until software clears it by writing a one to it.

The status word is split into two halves. Bits 31:16, each gated by the matching enable bit, form a level transmit interrupt. Bits 15:0, gated the same way, form a level receive interrupt. Writing the self-clearing software-reset bit of the command word starts a reset of fixed length. While it runs, every register reads as zero and bus writes and DMA events have no effect. When it ends, every register holds its default value.

Accesses use byte addresses. The word index is the address divided by four, and the two low address bits must be zero. Read data is registered.

Top module: `macirq_regbank`

## Requirements
- R1: After the synchronous reset, reads return these defaults: 0x00 command 0, 0x04 enable 0, 0x08 status 0, 0x0C TX list base 0xFFFFFFFC, 0x10 RX list base 0xFFFFFFFC, 0x14 FIFO threshold 0x00000101, 0x18 max receive frame 0x00000800, 0x1C missed-frame counter 0x00007FFF, 0x20 management data/address 0x00900000. Both interrupt lines are low.
- R2: Command bits 8 (transmit on), 1 (accept long frames) and 0 (receive on) are read/write and drive `tx_on`, `long_ok` and `rx_on`. Every other command bit reads as zero.
- R3: A one on `tx_evt[i]` sets status bit 16+i, and a one on `rx_evt[i]` sets status bit i. The bit stays set until software clears it.
- R4: A write to the status word clears each bit written as one and leaves every bit written as zero. Writing 0xFFFF0000 clears only the transmit half.
- R5: When a status bit is set by an event in the same cycle that software clears it, the bit ends up set.
- R6: `irq_tx` is high exactly when some status bit in 31:16 and its enable bit are both set. It follows the register state one cycle later.
- R7: `irq_rx` follows the same rule over bits 15:0, independently of the transmit half.
- R8: Writing a command word with bit 24 set raises `rst_busy` for RST_CYCLES cycles (16 by default). During that time every read returns zero and both interrupt lines stay low.
- R9: While `rst_busy` is high, bus writes and event pulses leave no trace in any register.
- R10: When `rst_busy` falls, every register holds its R1 default, and command bit 24 reads as zero.
- R11: Reads from an unmapped word index or a misaligned address (low two bits not zero) return zero, and writes to them change nothing.
- R12: The configuration words at 0x0C to 0x20 are fully read/write. The TX and RX list bases drive `tx_list_base` and `rx_list_base`. Read data appears on `rdata` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address (word index times four) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_evt | input | 16 | Transmit DMA event pulses, set status bits 31:16 |
| rx_evt | input | 16 | Receive DMA event pulses, set status bits 15:0 |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_rx | output | 1 | Receive interrupt level |
| tx_on | output | 1 | Command bit 8 |
| rx_on | output | 1 | Command bit 0 |
| long_ok | output | 1 | Command bit 1 |
| rst_busy | output | 1 | Software reset in progress |
| tx_list_base | output | 32 | TX descriptor-list start address |
| rx_list_base | output | 32 | RX descriptor-list start address |

## Verification
Status-word behaviour is tried with several patterns:
- an event with its enable clear and then set, which separates latching from gating;
- events in both halves followed by an upper-half clear mask, which shows whether the two halves are independent;
- a clear that lands in the same cycle as a set of the same bit, which shows the priority.

The software reset is tried twice:
- once idle, which measures its exact length and the defaults it leaves behind;
- once with reads, a write and event pulses issued while it runs, which exposes any access that leaks through.

Unmapped and misaligned accesses use data that would be visible if decoded, so an aliasing decoder is caught.

// File: rtl/macirq_pkg.sv
package macirq_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  // word indices (byte address = index * 4)
  localparam int IDX_CMD  = 0;
  localparam int IDX_IEN  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_CFG  = 3;
  localparam int NUM_CFG  = 6;

  // command word fields
  localparam int CMD_SRST = 24;
  localparam int CMD_TXEN = 8;
  localparam int CMD_LONG = 1;
  localparam int CMD_RXEN = 0;
  localparam logic [WORD_W-1:0] CMD_RW_MASK =
    (WORD_W'(1) << CMD_TXEN) | (WORD_W'(1) << CMD_LONG) | (WORD_W'(1) << CMD_RXEN);

  // configuration slots, relative to IDX_CFG
  localparam int CFG_TXLIST = 0;
  localparam int CFG_RXLIST = 1;
  localparam int CFG_FIFO   = 2;
  localparam int CFG_RXMAX  = 3;
  localparam int CFG_MISS   = 4;
  localparam int CFG_MDIO   = 5;

  function automatic logic [WORD_W-1:0] cfg_default(input int slot);
    logic [WORD_W-1:0] v;
    case (slot)
      CFG_TXLIST, CFG_RXLIST: v = 32'hFFFF_FFFC;
      CFG_FIFO:               v = 32'h0000_0101;
      CFG_RXMAX:              v = 32'h0000_0800;
      CFG_MISS:               v = 32'h0000_7FFF;
      CFG_MDIO:               v = 32'h0090_0000;
      default:                v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/macirq_softrst.sv
// Software reset sequencer: a start pulse holds busy for RST_CYCLES cycles.
module macirq_softrst #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES + 1) : 1;

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!busy) begin
      remain <= CNT_W'(RST_CYCLES - 1);
      if (start) busy <= 1'b1;
    end else if (remain == '0) begin
      busy <= 1'b0;
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/macirq_cfgbank.sv
// Plain read/write configuration words with per-slot defaults.
module macirq_cfgbank
  import macirq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int NUM   = NUM_CFG,
  parameter int BASE  = IDX_CFG
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       wr_ok,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WORD_W-1:0]          wdata,
  output logic [NUM-1:0][WORD_W-1:0] q
);
  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic [WORD_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst || flush)
        r <= cfg_default(g);
      else if (wr_ok && wr_idx == IDX_W'(BASE + g))
        r <= wdata;
    end
    assign q[g] = r;
  end
endmodule

// File: rtl/macirq_status.sv
// Sticky event status split into groups, each with its own gated interrupt.
module macirq_status #(
  parameter int WORD_W  = 32,
  parameter int NUM_GRP = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [WORD_W-1:0]  set,
  input  logic [WORD_W-1:0]  clr,
  input  logic [WORD_W-1:0]  en,
  output logic [WORD_W-1:0]  stat,
  output logic [NUM_GRP-1:0] irq
);
  localparam int GRP_W = WORD_W / NUM_GRP;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] s;
    logic             line;
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        s    <= '0;
        line <= 1'b0;
      end else begin
        // a set in the same cycle as a clear wins
        s    <= (s & ~clr[g*GRP_W +: GRP_W]) | set[g*GRP_W +: GRP_W];
        line <= |(s & en[g*GRP_W +: GRP_W]);
      end
    end
    assign stat[g*GRP_W +: GRP_W] = s;
    assign irq[g] = line;
  end
endmodule

// File: rtl/macirq_regbank.sv
module macirq_regbank
  import macirq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [HALF_W-1:0] tx_evt,
  input  logic [HALF_W-1:0] rx_evt,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              tx_on,
  output logic              rx_on,
  output logic              long_ok,
  output logic              rst_busy,
  output logic [WORD_W-1:0] tx_list_base,
  output logic [WORD_W-1:0] rx_list_base
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]           idx;
  logic                       aligned;
  logic                       busy;
  logic                       wr_ok;
  logic                       srst_start;
  logic [WORD_W-1:0]          cmd_q;
  logic [WORD_W-1:0]          en_q;
  logic [WORD_W-1:0]          stat_q;
  logic [WORD_W-1:0]          stat_clr;
  logic [1:0]                 irq_v;
  logic [NUM_CFG-1:0][WORD_W-1:0] cfg_q;
  logic [WORD_W-1:0]          rd_word;

  assign idx        = addr[ADDR_W-1:2];
  assign aligned    = (addr[1:0] == 2'b00);
  assign wr_ok      = wr_en && aligned && !busy;
  assign srst_start = wr_ok && (idx == IDX_W'(IDX_CMD)) && wdata[CMD_SRST];
  assign stat_clr   = (wr_ok && idx == IDX_W'(IDX_STAT)) ? wdata : '0;

  macirq_softrst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk  (clk),
    .rst  (rst),
    .start(srst_start),
    .busy (busy)
  );

  // command and enable words
  always_ff @(posedge clk) begin
    if (rst || srst_start) begin
      cmd_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_ok && idx == IDX_W'(IDX_CMD)) cmd_q <= wdata & CMD_RW_MASK;
      if (wr_ok && idx == IDX_W'(IDX_IEN)) en_q  <= wdata;
    end
  end

  macirq_status #(.WORD_W(WORD_W), .NUM_GRP(2)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .flush(busy || srst_start),
    .set  ({tx_evt, rx_evt}),
    .clr  (stat_clr),
    .en   (en_q),
    .stat (stat_q),
    .irq  (irq_v)
  );

  macirq_cfgbank #(.IDX_W(IDX_W), .NUM(NUM_CFG), .BASE(IDX_CFG)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .flush (srst_start),
    .wr_ok (wr_ok),
    .wr_idx(idx),
    .wdata (wdata),
    .q     (cfg_q)
  );

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if (idx == IDX_W'(IDX_CMD))  rd_word = cmd_q;
      if (idx == IDX_W'(IDX_IEN))  rd_word = en_q;
      if (idx == IDX_W'(IDX_STAT)) rd_word = stat_q;
      for (int i = 0; i < NUM_CFG; i++) begin
        if (idx == IDX_W'(IDX_CFG + i)) rd_word = cfg_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_en)  rdata <= busy ? '0 : rd_word;
  end

  assign irq_rx       = irq_v[0];
  assign irq_tx       = irq_v[1];
  assign tx_on        = cmd_q[CMD_TXEN];
  assign rx_on        = cmd_q[CMD_RXEN];
  assign long_ok      = cmd_q[CMD_LONG];
  assign rst_busy     = busy;
  assign tx_list_base = cfg_q[CFG_TXLIST];
  assign rx_list_base = cfg_q[CFG_RXLIST];
endmodule

// File: rtl/macirq_regbank_chk.sv
module macirq_regbank_chk #(
  parameter int ADDR_W     = 6,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [15:0]       tx_evt,
  input logic [15:0]       rx_evt,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              tx_on,
  input logic              rx_on,
  input logic              long_ok,
  input logic              rst_busy,
  input logic [31:0]       tx_list_base,
  input logic [31:0]       rx_list_base,
  input logic [31:0]       stat_q,
  input logic [31:0]       en_q
);
  localparam int LEN_W = $clog2(RST_CYCLES + 2) + 1;

  logic [31:0]      evt_w;
  logic             start_w;
  logic             stat_wr;
  logic [LEN_W-1:0] busy_len;

  assign evt_w   = {tx_evt, rx_evt};
  assign start_w = wr_en && (addr == '0) && wdata[24] && !rst_busy;
  assign stat_wr = wr_en && (addr == ADDR_W'(8)) && !rst_busy;

  always_ff @(posedge clk) begin
    if (rst)           busy_len <= '0;
    else if (rst_busy) busy_len <= busy_len + 1'b1;
    else               busy_len <= '0;
  end

  assert_evt_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_w != '0 && !rst_busy && !start_w) |=> ((stat_q & $past(evt_w)) == $past(evt_w)));

  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && evt_w == '0) |=> ((stat_q & $past(wdata)) == '0));

  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (en_q[31:16] == '0) |=> !irq_tx);

  assert_rx_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q[15:0] == '0) |=> !irq_rx);

  assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_busy && $past(rst_busy)) |-> (!irq_tx && !irq_rx));

  assert_zero_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rst_busy) |=> (rdata == '0));

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_busy) |-> (busy_len == LEN_W'(RST_CYCLES)));

  assert_hold_bases_R9: assert property (@(posedge clk) disable iff (rst)
    rst_busy |=> ($stable(tx_list_base) && $stable(rx_list_base)));

  assert_defaults_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_busy) |-> (tx_list_base == 32'hFFFF_FFFC && rx_list_base == 32'hFFFF_FFFC
                         && !tx_on && !rx_on && !long_ok));
endmodule

bind macirq_regbank macirq_regbank_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .tx_evt(tx_evt), .rx_evt(rx_evt), .irq_tx(irq_tx), .irq_rx(irq_rx),
  .tx_on(tx_on), .rx_on(rx_on), .long_ok(long_ok), .rst_busy(rst_busy),
  .tx_list_base(tx_list_base), .rx_list_base(rx_list_base),
  .stat_q(stat_q), .en_q(en_q)
);

// File: tb/macirq_regbank_bench.sv
module macirq_regbank_bench;
  localparam int ADDR_W = 6;
  localparam int RSTC   = 16;

  localparam logic [5:0] A_CMD = 6'h00, A_IEN = 6'h04, A_STAT = 6'h08,
                         A_TXL = 6'h0C, A_RXL = 6'h10, A_FIFO = 6'h14,
                         A_RXMAX = 6'h18, A_MISS = 6'h1C, A_MDIO = 6'h20,
                         A_HOLE = 6'h30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] tx_evt = '0, rx_evt = '0;
  logic [31:0] rdata, tx_list_base, rx_list_base;
  logic        irq_tx, irq_rx, tx_on, rx_on, long_ok, rst_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  macirq_regbank #(.ADDR_W(ADDR_W), .RST_CYCLES(RSTC)) u_macirq_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tx_evt(tx_evt), .rx_evt(rx_evt), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .tx_on(tx_on), .rx_on(rx_on), .long_ok(long_ok), .rst_busy(rst_busy),
    .tx_list_base(tx_list_base), .rx_list_base(rx_list_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse(input logic [15:0] t, input logic [15:0] r);
    @(negedge clk); tx_evt = t; rx_evt = r;
    @(negedge clk); tx_evt = '0; rx_evt = '0;
  endtask

  task automatic check_defaults(input string req);
    rd_chk(req, A_CMD, 32'h0);
    rd_chk(req, A_IEN, 32'h0);
    rd_chk(req, A_STAT, 32'h0);
    rd_chk(req, A_TXL, 32'hFFFF_FFFC);
    rd_chk(req, A_RXL, 32'hFFFF_FFFC);
    rd_chk(req, A_FIFO, 32'h0000_0101);
    rd_chk(req, A_RXMAX, 32'h0000_0800);
    rd_chk(req, A_MISS, 32'h0000_7FFF);
    rd_chk(req, A_MDIO, 32'h0090_0000);
    chk(req, {30'd0, irq_tx, irq_rx}, 32'h0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_defaults("R1");
    chk("R1 list base pin", tx_list_base, 32'hFFFF_FFFC);
  endtask

  task automatic t_cmd;
    bus_wr(A_CMD, 32'h00FF_FFFF);
    rd_chk("R2", A_CMD, 32'h0000_0103);
    chk("R2 pins", {29'd0, tx_on, long_ok, rx_on}, 32'h7);
    bus_wr(A_CMD, 32'h0000_0100);
    chk("R2 pins tx only", {29'd0, tx_on, long_ok, rx_on}, 32'h4);
    bus_wr(A_CMD, 32'h0);
  endtask

  task automatic t_irq;
    pulse(16'h0004, 16'h0000);
    rd_chk("R3", A_STAT, 32'h0004_0000);
    chk("R6 gated off", {31'd0, irq_tx}, 32'h0);
    bus_wr(A_IEN, 32'h0004_0000);
    @(negedge clk);
    chk("R6 tx line", {30'd0, irq_tx, irq_rx}, 32'h2);
    pulse(16'h0000, 16'h0010);
    rd_chk("R3 sticky", A_STAT, 32'h0004_0010);
    chk("R7 gated off", {31'd0, irq_rx}, 32'h0);
    bus_wr(A_IEN, 32'h0004_0010);
    @(negedge clk);
    chk("R7 rx line", {30'd0, irq_tx, irq_rx}, 32'h3);
  endtask

  task automatic t_w1c;
    pulse(16'h0001, 16'h0001);
    rd_chk("R3 both halves", A_STAT, 32'h0005_0011);
    bus_wr(A_STAT, 32'hFFFF_0000);
    rd_chk("R4 upper clear", A_STAT, 32'h0000_0011);
    chk("R4 lines", {30'd0, irq_tx, irq_rx}, 32'h1);
    bus_wr(A_STAT, 32'h0000_0001);
    rd_chk("R4 single", A_STAT, 32'h0000_0010);
    bus_wr(A_STAT, 32'h0);
    rd_chk("R4 zero write", A_STAT, 32'h0000_0010);
    bus_wr(A_STAT, 32'h0000_0010);
    @(negedge clk);
    chk("R7 line drops", {31'd0, irq_rx}, 32'h0);
  endtask

  task automatic t_collide;
    pulse(16'h0004, 16'h0010);
    @(negedge clk);
    wr_en = 1'b1; addr = A_STAT; wdata = 32'h0004_0010; tx_evt = 16'h0004;
    @(negedge clk);
    wr_en = 1'b0; tx_evt = '0;
    rd_chk("R5 set wins", A_STAT, 32'h0004_0000);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_wr(A_IEN, 32'h0);
    rd_chk("R4 all clear", A_STAT, 32'h0);
  endtask

  task automatic t_cfg;
    bus_wr(A_TXL, 32'h1234_5670);
    bus_wr(A_RXL, 32'h0BAD_F00C);
    bus_wr(A_MISS, 32'h0000_0003);
    rd_chk("R12", A_TXL, 32'h1234_5670);
    rd_chk("R12", A_RXL, 32'h0BAD_F00C);
    rd_chk("R12", A_MISS, 32'h0000_0003);
    chk("R12 tx pin", tx_list_base, 32'h1234_5670);
    chk("R12 rx pin", rx_list_base, 32'h0BAD_F00C);
  endtask

  task automatic t_unmapped;
    bus_wr(A_HOLE, 32'hDEAD_BEEF);
    rd_chk("R11 hole", A_HOLE, 32'h0);
    bus_wr(A_TXL + 6'd1, 32'h1111_1111);
    rd_chk("R11 misaligned write", A_TXL, 32'h1234_5670);
    rd_chk("R11 misaligned read", A_TXL + 6'd1, 32'h0);
  endtask

  task automatic t_srst_len;
    int n;
    bus_wr(A_CMD, 32'h0000_0103);
    bus_wr(A_IEN, 32'hFFFF_FFFF);
    pulse(16'h0080, 16'h0400);
    @(negedge clk);
    chk("R6 pre reset", {30'd0, irq_tx, irq_rx}, 32'h3);
    bus_wr(A_CMD, 32'h0100_0000);
    n = 0;
    while (rst_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R8 busy length", n, RSTC);
    check_defaults("R10");
    chk("R10 pins", {29'd0, tx_on, long_ok, rx_on}, 32'h0);
  endtask

  task automatic t_srst_access;
    bus_wr(A_CMD, 32'h0100_0000);
    chk("R8 busy", {31'd0, rst_busy}, 32'h1);
    rd_chk("R8 zero read", A_FIFO, 32'h0);
    bus_wr(A_TXL, 32'h5555_0000);
    pulse(16'hFFFF, 16'hFFFF);
    rd_chk("R8 cmd zero", A_CMD, 32'h0);
    while (rst_busy) @(negedge clk);
    rd_chk("R9 write dropped", A_TXL, 32'hFFFF_FFFC);
    rd_chk("R9 events dropped", A_STAT, 32'h0);
    rd_chk("R10 fifo", A_FIFO, 32'h0000_0101);
  endtask

  initial begin
    t_reset();
    t_cmd();
    t_irq();
    t_w1c();
    t_collide();
    t_cfg();
    t_unmapped();
    t_srst_len();
    t_srst_access();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule